// File: doc/BRIEF.md
# Quasi-Cyclic Message Rotation Network

This block sits between the variable-node memories and the check-node processor of a semi-parallel quasi-cyclic LDPC decoder. Each cycle it takes one group of `Z` soft messages that belong to one sub-block of the base matrix. It looks up the cyclic shift for that sub-block, rotates the group to the right by that amount, and hands the result to the check-node side. The shift depends on the sub-block position and on the code-rate mode.

The shift lookup is computed inside the block. Its result is a 7-bit word, and the all-ones word is reserved to mark an all-zero sub-block. Such a sub-block carries no messages, so no output valid is produced for it. The rotation is done by a logarithmic barrel shifter that works modulo `Z`, so `Z` need not be a power of two. One or two register stages, chosen by parameter, follow the rotator. The valid strobe passes through the same number of stages.

A new sub-block may be presented every cycle. The output registers load only when they take in a real result, so the output data stays constant while no valid result arrives.

Top module: `qc_shuffle_net`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `outValid` is 0 and `outMsgs` is all zeros.
- R2: For a valid result with shift `s`, output lane `i` (bits `i*MSG_W +: MSG_W`) equals input lane `(i - s) mod Z` for every `i` from 0 to `Z-1`. This is a right rotation.
- R3: For a non-blank sub-block, the shift is `s = (37*row + 11*col + 19*mode + 5) mod Z`, and it always lies between 0 and `Z-1`.
- R4: `rateMode` is encoded as 0=rate 1/2, 1=2/3A, 2=2/3B, 3=3/4A, 4=3/4B and 5=5/6. These modes use 12, 8, 8, 6, 6 and 4 base rows. Codes 6 and 7 are reserved and never produce an output valid.
- R5: A sub-block is blank, so `inValid` is not passed on, when `row >= rows(mode)`, or `col >= BASE_COLS` (24), or `(row + 2*col + mode) mod 5 == 0`.
- R6: `outValid` and its data appear exactly `PIPE_STAGES` cycles (1 or 2) after the edge that samples an accepted input.
- R7: When no valid result reaches the output (blank sub-block, reserved mode or idle input), `outMsgs` keeps its previous value.
- R8: While `inValid` is 0, no result is produced, whatever the other inputs are.
- R9: Sub-blocks presented on consecutive cycles each produce their own result, on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | The input group is present this cycle |
| inMsgs | input | Z*MSG_W | Input messages; lane i at bits i*MSG_W +: MSG_W |
| rowIdx | input | clog2(BASE_ROWS) | Base-matrix row of the sub-block |
| colIdx | input | clog2(BASE_COLS) | Base-matrix column of the sub-block |
| rateMode | input | 3 | Code-rate mode (encoding in R4) |
| outValid | output | 1 | A rotated group is present on outMsgs |
| outMsgs | output | Z*MSG_W | Rotated messages, same lane layout |

## Verification
The hardest case to reach from the ports is an output hold that overlaps a result still in flight in the two-stage pipeline. This happens when a blank or idle slot lands directly behind a valid one, which is exactly where a stage register that loads without qualification would break R7. The stimulus sweeps every position of every mode back to back, so blank sub-blocks fall between valid ones in every arrangement. A final random phase then mixes idle slots, reserved modes and out-of-range positions, while one-stage and two-stage instances run side by side against a behavioural queue model.

// File: rtl/qcsn_pkg.sv
package qcsn_pkg;

  localparam int SHIFT_W = 7;
  localparam int MODE_W  = 3;
  localparam logic [SHIFT_W-1:0] BLANK_WORD = '1;

  typedef enum logic [MODE_W-1:0] {
    RATE_1_2  = 3'd0,
    RATE_2_3A = 3'd1,
    RATE_2_3B = 3'd2,
    RATE_3_4A = 3'd3,
    RATE_3_4B = 3'd4,
    RATE_5_6  = 3'd5
  } rateMode_e;

  typedef struct packed {
    logic               fire;
    logic [SHIFT_W-1:0] amount;
  } rotCtrl_t;

  function automatic int activeRows(input logic [MODE_W-1:0] mode);
    case (mode)
      RATE_1_2:             return 12;
      RATE_2_3A, RATE_2_3B: return 8;
      RATE_3_4A, RATE_3_4B: return 6;
      RATE_5_6:             return 4;
      default:              return 0;
    endcase
  endfunction

endpackage

// File: rtl/qcsn_shift_lookup.sv
module qcsn_shift_lookup
  import qcsn_pkg::*;
#(
  parameter int Z         = 96,
  parameter int BASE_ROWS = 12,
  parameter int BASE_COLS = 24,
  localparam int ROW_W    = $clog2(BASE_ROWS),
  localparam int COL_W    = $clog2(BASE_COLS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [ROW_W-1:0]  rowIdx,
  input  logic [COL_W-1:0]  colIdx,
  input  logic [MODE_W-1:0] rateMode,
  output rotCtrl_t          ctrl
);

  int                 sumVal;
  int                 keyVal;
  logic               posInRange;
  logic               blankCell;
  logic [SHIFT_W-1:0] romWord;

  always_comb begin
    sumVal     = 37 * int'(rowIdx) + 11 * int'(colIdx) + 19 * int'(rateMode) + 5;
    keyVal     = int'(rowIdx) + 2 * int'(colIdx) + int'(rateMode);
    posInRange = (int'(rateMode) <= 5)
              && (int'(rowIdx) < activeRows(rateMode))
              && (int'(rowIdx) < BASE_ROWS)
              && (int'(colIdx) < BASE_COLS);
    blankCell  = (keyVal % 5) == 0;
    romWord    = (posInRange && !blankCell) ? SHIFT_W'(sumVal % Z) : BLANK_WORD;
  end

  always_comb begin
    ctrl.fire   = inValid && (romWord != BLANK_WORD);
    ctrl.amount = ctrl.fire ? romWord : '0;
  end

  a_r8_no_fire_without_valid: assert property (@(posedge clk) disable iff (rst)
    !inValid |-> !ctrl.fire);

  a_r4_reserved_mode_silent: assert property (@(posedge clk) disable iff (rst)
    (rateMode > 3'd5) |-> !ctrl.fire);

  a_r3_amount_below_z: assert property (@(posedge clk) disable iff (rst)
    ctrl.fire |-> (int'(ctrl.amount) < Z));

endmodule

// File: rtl/qcsn_rotate_path.sv
module qcsn_rotate_path
  import qcsn_pkg::*;
#(
  parameter int Z           = 96,
  parameter int MSG_W       = 5,
  parameter int PIPE_STAGES = 2,
  localparam int NSTG       = $clog2(Z)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  rotCtrl_t                ctrl,
  input  logic [Z-1:0][MSG_W-1:0] inLanes,
  output logic                    outValid,
  output logic [Z-1:0][MSG_W-1:0] outLanes
);

  // barrel rotator, each level rotates right by 2^k mod Z
  logic [Z-1:0][MSG_W-1:0] lvl [NSTG+1];
  assign lvl[0] = inLanes;

  for (genvar k = 0; k < NSTG; k++) begin : g_level
    localparam int STEP = (1 << k) % Z;
    for (genvar i = 0; i < Z; i++) begin : g_lane
      localparam int SRC = (i + Z - STEP) % Z;
      assign lvl[k+1][i] = ctrl.amount[k] ? lvl[k][SRC] : lvl[k][i];
    end
  end

  // output pipeline, data registers load only behind a valid
  logic                    vPipe [PIPE_STAGES+1];
  logic [Z-1:0][MSG_W-1:0] dPipe [PIPE_STAGES+1];
  assign vPipe[0] = ctrl.fire;
  assign dPipe[0] = lvl[NSTG];

  for (genvar p = 0; p < PIPE_STAGES; p++) begin : g_pipe
    always_ff @(posedge clk) begin
      if (rst) begin
        vPipe[p+1] <= 1'b0;
        dPipe[p+1] <= '0;
      end else begin
        vPipe[p+1] <= vPipe[p];
        if (vPipe[p]) dPipe[p+1] <= dPipe[p];
      end
    end
  end

  assign outValid = vPipe[PIPE_STAGES];
  assign outLanes = dPipe[PIPE_STAGES];

  // cycles since reset, so the latency check never looks into reset
  logic [1:0] warmCnt;
  always_ff @(posedge clk) begin
    if (rst) warmCnt <= '0;
    else if (warmCnt < 2'(PIPE_STAGES)) warmCnt <= warmCnt + 2'd1;
  end

  a_r6_valid_latency: assert property (@(posedge clk) disable iff (rst)
    (warmCnt >= 2'(PIPE_STAGES)) |-> (outValid == $past(ctrl.fire, PIPE_STAGES)));

  a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> $stable(outLanes));

endmodule

// File: rtl/qc_shuffle_net.sv
module qc_shuffle_net
  import qcsn_pkg::*;
#(
  parameter int Z           = 96,
  parameter int MSG_W       = 5,
  parameter int BASE_ROWS   = 12,
  parameter int BASE_COLS   = 24,
  parameter int PIPE_STAGES = 2,
  localparam int ROW_W      = $clog2(BASE_ROWS),
  localparam int COL_W      = $clog2(BASE_COLS),
  localparam int BUS_W      = Z * MSG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [BUS_W-1:0]  inMsgs,
  input  logic [ROW_W-1:0]  rowIdx,
  input  logic [COL_W-1:0]  colIdx,
  input  logic [MODE_W-1:0] rateMode,
  output logic              outValid,
  output logic [BUS_W-1:0]  outMsgs
);

  if (PIPE_STAGES < 1 || PIPE_STAGES > 2) begin : g_bad_pipe
    $error("PIPE_STAGES must be 1 or 2");
  end
  if (Z < 2 || Z >= (1 << SHIFT_W)) begin : g_bad_z
    $error("Z must fit below the blank marker");
  end

  rotCtrl_t                ctrl;
  logic [Z-1:0][MSG_W-1:0] laneIn;
  logic [Z-1:0][MSG_W-1:0] laneOut;

  assign laneIn  = inMsgs;
  assign outMsgs = laneOut;

  qcsn_shift_lookup #(
    .Z(Z), .BASE_ROWS(BASE_ROWS), .BASE_COLS(BASE_COLS)
  ) u_lookup (
    .clk(clk), .rst(rst), .inValid(inValid),
    .rowIdx(rowIdx), .colIdx(colIdx), .rateMode(rateMode),
    .ctrl(ctrl)
  );

  qcsn_rotate_path #(
    .Z(Z), .MSG_W(MSG_W), .PIPE_STAGES(PIPE_STAGES)
  ) u_path (
    .clk(clk), .rst(rst), .ctrl(ctrl), .inLanes(laneIn),
    .outValid(outValid), .outLanes(laneOut)
  );

endmodule

// File: tb/qc_shuffle_net_tb.sv
module qc_shuffle_net_tb;

  localparam int Z  = 96;
  localparam int MW = 5;
  localparam int NR = 12;
  localparam int NC = 24;
  localparam int BW = Z * MW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          inValid  = 1'b0;
  logic [BW-1:0] inMsgs   = '0;
  logic [3:0]    rowIdx   = '0;
  logic [4:0]    colIdx   = '0;
  logic [2:0]    rateMode = '0;
  logic          ov2, ov1;
  logic [BW-1:0] od2, od1;

  qc_shuffle_net #(.Z(Z), .MSG_W(MW), .BASE_ROWS(NR), .BASE_COLS(NC), .PIPE_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inMsgs(inMsgs), .rowIdx(rowIdx),
    .colIdx(colIdx), .rateMode(rateMode), .outValid(ov2), .outMsgs(od2));

  qc_shuffle_net #(.Z(Z), .MSG_W(MW), .BASE_ROWS(NR), .BASE_COLS(NC), .PIPE_STAGES(1)) u_dut1 (
    .clk(clk), .rst(rst), .inValid(inValid), .inMsgs(inMsgs), .rowIdx(rowIdx),
    .colIdx(colIdx), .rateMode(rateMode), .outValid(ov1), .outMsgs(od1));

  int checks   = 0;
  int failures = 0;

  // reference state: two-stage queue and one-stage queue
  logic          m2v1 = 1'b0, m2v2 = 1'b0, m1v1 = 1'b0;
  logic [BW-1:0] m2d1 = '0, m2d2 = '0, m1d1 = '0;

  function automatic int refRows(input int mode);
    case (mode)
      0: return 12;
      1, 2: return 8;
      3, 4: return 6;
      5: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic bit refBlank(input int mode, input int row, input int col);
    return (mode > 5) || (row >= refRows(mode)) || (col >= NC) || (((row + 2*col + mode) % 5) == 0);
  endfunction

  function automatic int refShift(input int mode, input int row, input int col);
    return (37*row + 11*col + 19*mode + 5) % Z;
  endfunction

  function automatic logic [BW-1:0] refRotate(input logic [BW-1:0] v, input int s);
    logic [BW-1:0] r;
    for (int i = 0; i < Z; i++) r[i*MW +: MW] = v[((i - s + Z) % Z)*MW +: MW];
    return r;
  endfunction

  function automatic logic [BW-1:0] randVec();
    logic [BW-1:0] v;
    for (int i = 0; i < Z; i++) v[i*MW +: MW] = MW'($urandom);
    return v;
  endfunction

  task automatic checkOne(input string tag, input string who, input logic gotV, input logic expV,
                          input logic [BW-1:0] gotD, input logic [BW-1:0] expD);
    checks++;
    if (gotV !== expV) begin
      failures++;
      $display("FAIL %s %s valid got %0b exp %0b", tag, who, gotV, expV);
    end
    checks++;
    if (gotD !== expD) begin
      failures++;
      $display("FAIL %s %s data got %h exp %h", tag, who, gotD, expD);
    end
  endtask

  // inputs are already driven; advance one edge and compare at the falling edge
  task automatic step(input string tag);
    logic          fire;
    logic [BW-1:0] rot;
    fire = inValid && !refBlank(int'(rateMode), int'(rowIdx), int'(colIdx));
    rot  = refRotate(inMsgs, fire ? refShift(int'(rateMode), int'(rowIdx), int'(colIdx)) : 0);
    @(posedge clk);
    if (rst) begin
      m2v1 = 0; m2v2 = 0; m1v1 = 0; m2d1 = '0; m2d2 = '0; m1d1 = '0;
    end else begin
      if (m2v1) m2d2 = m2d1;
      m2v2 = m2v1;
      if (fire) begin m2d1 = rot; m1d1 = rot; end
      m2v1 = fire;
      m1v1 = fire;
    end
    @(negedge clk);
    checkOne(tag, "two-stage", ov2, m2v2, od2, m2d2);
    checkOne(tag, "one-stage", ov1, m1v1, od1, m1d1);
  endtask

  task automatic drive(input logic v, input int mode, input int row, input int col);
    inValid  = v;
    rateMode = 3'(mode);
    rowIdx   = 4'(row);
    colIdx   = 5'(col);
    inMsgs   = randVec();
  endtask

  initial begin
    #(10 * 150000);
    failures++;
    $display("FAIL R9 watchdog got running exp finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1: reset state, inputs active to show reset dominates
    for (int c = 0; c < 3; c++) begin
      drive(1'b1, 0, 1, c + 1);
      step("R1");
    end
    rst = 1'b0;
    drive(1'b0, 0, 0, 0);
    step("R1");

    // R2, R3, R5, R9: every position of every mode, back to back
    for (int m = 0; m < 6; m++)
      for (int r = 0; r < NR; r++)
        for (int c = 0; c < NC; c++) begin
          drive(1'b1, m, r, c);
          step("R2,R3,R5,R9");
        end

    // R4: reserved mode codes, after a valid result so holding is visible
    drive(1'b1, 0, 0, 1);
    step("R4");
    for (int n = 0; n < 64; n++) begin
      drive(1'b1, 6 + (n % 2), $urandom_range(0, 11), $urandom_range(0, 23));
      step("R4");
    end

    // R5: rows and columns outside the mode's active area
    for (int n = 0; n < 120; n++) begin
      if (n % 2 == 0) drive(1'b1, $urandom_range(0, 5), $urandom_range(12, 15), $urandom_range(0, 31));
      else            drive(1'b1, 5, $urandom_range(4, 15), $urandom_range(24, 31));
      step("R5");
    end

    // R8 and R7: idle input with live positions, right behind a valid one
    drive(1'b1, 1, 0, 1);
    step("R7,R8");
    for (int n = 0; n < 80; n++) begin
      drive(1'b0, $urandom_range(0, 5), $urandom_range(0, 11), $urandom_range(0, 23));
      step("R7,R8");
    end

    // R6, R7, R9: random mix of valid, idle and blank slots
    for (int n = 0; n < 400; n++) begin
      drive(($urandom_range(0, 3) != 0), $urandom_range(0, 7), $urandom_range(0, 15), $urandom_range(0, 31));
      step("R6,R7,R9");
    end

    drive(1'b0, 0, 0, 0);
    step("R6");
    step("R6");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule